// File: doc/BRIEF.md
# USB Endpoint Buffer-Descriptor Handshake Engine

This block sits between the packet layer of a USB device and the firmware. For one endpoint it keeps a buffer descriptor (a status byte, the low eight bits of a byte count and a buffer address), which the CPU fills in and hands over by setting an ownership bit. When a token arrives, the engine reads the descriptor and picks the handshake. It gates the byte writes into the buffer RAM. When the transaction completes it writes the result back into the descriptor and passes ownership back to the CPU.

The CPU arms the endpoint by writing the address, then the low count, and then the status byte with the ownership bit set. The status byte goes last because it makes the descriptor live. While it owns the descriptor, the engine applies data-toggle synchronisation, stall handling and buffer-length truncation. A completed transaction rewrites the status byte in a different layout: the ownership bit is clear, bit 6 holds the received toggle, bits 5:2 hold the token PID and bits 1:0 hold the top count bits.

Top module: `ep_bd_engine`

## Requirements
- R1: After reset the status byte, low count and address read as zero, and `hsValid`, `trnDone`, `stallIrq`, `epStall` and `ramWe` are low.
- R2: A CPU write takes effect on the next clock. `cpuSel` selects the target: 0 is the status byte, 1 is the low count byte, 2 is the address. The buffer length is `{status[1:0], countLo}` (10 bits). In the status byte, bit 7 is ownership, bit 6 is the expected toggle, bit 3 enables toggle synchronisation and bit 2 requests a buffer stall.
- R3: When the ownership bit is 0, an OUT or SETUP data packet gets a NAK (`hsCode`=2). No RAM write occurs, and the transaction raises no completion.
- R4: When synchronisation is enabled and the received toggle matches bit 6, an error-free OUT packet gets an ACK (`hsCode`=1). Its bytes are written from the buffer address upward, and `trnDone` pulses. The status becomes `{0, toggle, PID, count[9:8]}` with OUT PID 4'b0001, and the low count becomes the received count.
- R5: When synchronisation is enabled and the toggle does not match, the packet is still ACKed. No RAM write occurs, `trnDone` stays low and the descriptor is unchanged.
- R6: When synchronisation is disabled, an error-free packet with either toggle (`pidTgl`=0 for DATA0, 1 for DATA1) is ACKed, written and completed.
- R7: A packet that ends with `rxErr` gets a NAK. The descriptor is unchanged and the transaction raises no completion.
- R8: When the engine owns the descriptor and bit 2 is set, an OUT or IN token gets a STALL (`hsCode`=3), `stallIrq` pulses and `epStall` is set. The descriptor is unchanged and no RAM write occurs. A CPU write to the status byte clears `epStall`.
- R9: A SETUP token on a stalled descriptor is accepted like an OUT packet. It writes the SETUP PID 4'b1101 and returns ownership to the CPU, which ends the stall.
- R10: An IN token on an owned, non-stalled descriptor is answered with `hsCode`=0 (send data). `trnDone` pulses, the status becomes `{0, bit6, 4'b1001, status[1:0]}`, and the low count is kept.
- R11: RAM writes stop once the byte index reaches the buffer length, and the written-back count is the full number of bytes received.
- R12: The descriptor takes part in a transaction only once the status byte is written with bit 7 set. Writing only the address and count leaves the endpoint answering NAK.
- R13: The handshake, completion and descriptor update all appear one clock after an IN token or after `eopValid`. `hsValid` stays low during the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWe | input | 1 | CPU descriptor write strobe |
| cpuSel | input | 2 | 0 status, 1 low count, 2 address |
| cpuWData | input | ADDR_W | CPU write data (status/count use bits 7:0) |
| descStat | output | 8 | Descriptor status byte |
| descCntLo | output | 8 | Descriptor low count byte |
| descAddr | output | ADDR_W | Descriptor buffer address |
| tokValid | input | 1 | Token received strobe |
| tokType | input | 2 | 1 OUT, 2 IN, 3 SETUP |
| pidValid | input | 1 | Data PID received strobe |
| pidTgl | input | 1 | 0 DATA0, 1 DATA1 |
| byteValid | input | 1 | Data byte strobe |
| byteData | input | 8 | Data byte |
| eopValid | input | 1 | End of data packet strobe |
| rxErr | input | 1 | Packet error, valid with eopValid |
| hsValid | output | 1 | Handshake decision strobe |
| hsCode | output | 2 | 0 send data, 1 ACK, 2 NAK, 3 STALL |
| ramWe | output | 1 | Buffer RAM write enable |
| ramAddr | output | ADDR_W | Buffer RAM write address |
| ramData | output | 8 | Buffer RAM write data |
| trnDone | output | 1 | Transfer-complete pulse |
| epStall | output | 1 | Sticky endpoint stall flag |
| stallIrq | output | 1 | Stall interrupt pulse |

## Verification
The assertions assume that the packet layer handles one transaction at a time. A data packet is expected to arrive in order: token, then the data PID, then the bytes, then end of packet. A byte is never expected in the same cycle as the end of packet. The assertions also assume that no token arrives while a packet is still open, and that the CPU does not write the descriptor while the engine is inside a transaction. The stimulus drives every packet strictly in that order, one strobe per cycle, and touches the descriptor only between transactions.

// File: rtl/ep_bd_pkg.sv
package ep_bd_pkg;
  localparam int CNT_W = 10;

  localparam int OWN_BIT   = 7;
  localparam int TGL_BIT   = 6;
  localparam int SYNC_BIT  = 3;
  localparam int STALL_BIT = 2;

  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_ADDR = 2'd2;

  localparam logic [3:0] PID_OUT   = 4'b0001;
  localparam logic [3:0] PID_IN    = 4'b1001;
  localparam logic [3:0] PID_SETUP = 4'b1101;

  typedef enum logic [1:0] {
    TOK_NONE  = 2'd0,
    TOK_OUT   = 2'd1,
    TOK_IN    = 2'd2,
    TOK_SETUP = 2'd3
  } tok_e;

  typedef enum logic [1:0] {
    HS_DATA  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  typedef struct packed {
    logic       idxClr;
    logic       wrGate;
    logic       wbEn;
    logic       wbUseRx;
    logic [3:0] wbPid;
    logic       wbTgl;
    logic       stallSet;
  } strobe_t;
endpackage

// File: rtl/ep_bd_dp.sv
module ep_bd_dp
  import ep_bd_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWe,
  input  logic [1:0]        cpuSel,
  input  logic [ADDR_W-1:0] cpuWData,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  strobe_t           stb,
  output logic [7:0]        statQ,
  output logic [7:0]        cntLoQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramData,
  output logic              stallQ
);
  logic [CNT_W-1:0] idxQ;
  logic [CNT_W-1:0] bufLen;
  logic             wrStat, wrCnt, wrAddr;
  logic             idxFull;

  assign bufLen  = {statQ[1:0], cntLoQ};
  assign wrStat  = cpuWe && (cpuSel == SEL_STAT);
  assign wrCnt   = cpuWe && (cpuSel == SEL_CNT);
  assign wrAddr  = cpuWe && (cpuSel == SEL_ADDR);
  assign idxFull = &idxQ;

  // received byte index, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                      idxQ <= '0;
    else if (stb.idxClr)            idxQ <= '0;
    else if (byteValid && !idxFull) idxQ <= idxQ + 1'b1;
  end

  // status byte: CPU write wins over engine write-back
  always_ff @(posedge clk) begin
    if (!rstN)           statQ <= '0;
    else if (wrStat)     statQ <= cpuWData[7:0];
    else if (stb.wbEn)   statQ <= {1'b0, stb.wbTgl, stb.wbPid,
                                   stb.wbUseRx ? idxQ[CNT_W-1:8] : statQ[1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN)                       cntLoQ <= '0;
    else if (wrCnt)                  cntLoQ <= cpuWData[7:0];
    else if (stb.wbEn && stb.wbUseRx) cntLoQ <= idxQ[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)       addrQ <= '0;
    else if (wrAddr) addrQ <= cpuWData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             stallQ <= 1'b0;
    else if (stb.stallSet) stallQ <= 1'b1;
    else if (wrStat)       stallQ <= 1'b0;
  end

  assign ramWe   = byteValid && stb.wrGate && (idxQ < bufLen);
  assign ramAddr = addrQ + ADDR_W'(idxQ);
  assign ramData = byteData;

  AST_WE_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> statQ[OWN_BIT]);                                    // R3
  AST_STALL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    stb.stallSet |=> stallQ);                                     // R8
  AST_WB_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wbEn && !cpuWe) |=> !statQ[OWN_BIT]);                    // R4
endmodule

// File: rtl/ep_bd_ctrl.sv
module ep_bd_ctrl
  import ep_bd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ownBit,
  input  logic       stallBit,
  input  logic       syncBit,
  input  logic       dtsBit,
  input  logic       tokValid,
  input  logic [1:0] tokType,
  input  logic       pidValid,
  input  logic       pidTgl,
  input  logic       eopValid,
  input  logic       rxErr,
  output strobe_t    stb,
  output logic       hsValid,
  output logic [1:0] hsCode,
  output logic       trnDone,
  output logic       stallIrq
);
  typedef enum logic [1:0] {
    M_ACCEPT = 2'd0,
    M_NAK    = 2'd1,
    M_STALL  = 2'd2
  } mode_e;

  logic  inPktQ, pidSeenQ, rxTglQ, isSetupQ;
  mode_e modeQ, modeNext;
  logic  stalled, tglOk, evIn, evData, evEop, goodEop;
  logic [1:0] hsNext;

  assign stalled = ownBit && stallBit;
  assign tglOk   = !syncBit || (rxTglQ == dtsBit);
  assign evIn    = tokValid && !inPktQ && (tokType == TOK_IN);
  assign evData  = tokValid && !inPktQ &&
                   ((tokType == TOK_OUT) || (tokType == TOK_SETUP));
  assign evEop   = eopValid && inPktQ;
  assign goodEop = evEop && (modeQ == M_ACCEPT) && pidSeenQ && !rxErr && tglOk;

  always_comb begin
    if (!ownBit)                                      modeNext = M_NAK;
    else if (stalled && (tokType != TOK_SETUP))       modeNext = M_STALL;
    else                                              modeNext = M_ACCEPT;
  end

  always_comb begin
    stb          = '0;
    stb.idxClr   = evData;
    stb.wrGate   = inPktQ && (modeQ == M_ACCEPT) && pidSeenQ && tglOk;
    stb.wbEn     = goodEop || (evIn && ownBit && !stallBit);
    stb.wbUseRx  = goodEop;
    stb.wbPid    = evIn ? PID_IN : (isSetupQ ? PID_SETUP : PID_OUT);
    stb.wbTgl    = evIn ? dtsBit : rxTglQ;
    stb.stallSet = (evIn && stalled) || (evEop && (modeQ == M_STALL));
  end

  always_comb begin
    if (evIn) begin
      if (!ownBit)       hsNext = HS_NAK;
      else if (stallBit) hsNext = HS_STALL;
      else               hsNext = HS_DATA;
    end else begin
      case (modeQ)
        M_NAK:   hsNext = HS_NAK;
        M_STALL: hsNext = HS_STALL;
        default: hsNext = (rxErr || !pidSeenQ) ? HS_NAK : HS_ACK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPktQ   <= 1'b0;
      pidSeenQ <= 1'b0;
      rxTglQ   <= 1'b0;
      isSetupQ <= 1'b0;
      modeQ    <= M_NAK;
    end else begin
      if (evData) begin
        inPktQ   <= 1'b1;
        pidSeenQ <= 1'b0;
        isSetupQ <= (tokType == TOK_SETUP);
        modeQ    <= modeNext;
      end else if (evEop) begin
        inPktQ   <= 1'b0;
      end
      if (pidValid && inPktQ) begin
        pidSeenQ <= 1'b1;
        rxTglQ   <= pidTgl;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsValid  <= 1'b0;
      hsCode   <= HS_DATA;
      trnDone  <= 1'b0;
      stallIrq <= 1'b0;
    end else begin
      hsValid  <= evIn || evEop;
      hsCode   <= (evIn || evEop) ? hsNext : hsCode;
      trnDone  <= stb.wbEn;
      stallIrq <= stb.stallSet;
    end
  end

  AST_DONE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rstN)
    trnDone |-> (hsValid && ((hsCode == HS_ACK) || (hsCode == HS_DATA))));  // R4
  AST_IRQ_STALL: assert property (@(posedge clk) disable iff (!rstN)
    stallIrq |-> (hsValid && (hsCode == HS_STALL)));                        // R8
  AST_NAK_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (hsValid && (hsCode == HS_NAK)) |-> !trnDone);                          // R7
  AST_NO_GATE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inPktQ |-> !stb.wrGate);                                               // R3
endmodule

// File: rtl/ep_bd_engine.sv
module ep_bd_engine
  import ep_bd_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWe,
  input  logic [1:0]        cpuSel,
  input  logic [ADDR_W-1:0] cpuWData,
  output logic [7:0]        descStat,
  output logic [7:0]        descCntLo,
  output logic [ADDR_W-1:0] descAddr,
  input  logic              tokValid,
  input  logic [1:0]        tokType,
  input  logic              pidValid,
  input  logic              pidTgl,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              eopValid,
  input  logic              rxErr,
  output logic              hsValid,
  output logic [1:0]        hsCode,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramData,
  output logic              trnDone,
  output logic              epStall,
  output logic              stallIrq
);
  strobe_t stb;

  ep_bd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ownBit   (descStat[OWN_BIT]),
    .stallBit (descStat[STALL_BIT]),
    .syncBit  (descStat[SYNC_BIT]),
    .dtsBit   (descStat[TGL_BIT]),
    .tokValid (tokValid),
    .tokType  (tokType),
    .pidValid (pidValid),
    .pidTgl   (pidTgl),
    .eopValid (eopValid),
    .rxErr    (rxErr),
    .stb      (stb),
    .hsValid  (hsValid),
    .hsCode   (hsCode),
    .trnDone  (trnDone),
    .stallIrq (stallIrq)
  );

  ep_bd_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cpuWe     (cpuWe),
    .cpuSel    (cpuSel),
    .cpuWData  (cpuWData),
    .byteValid (byteValid),
    .byteData  (byteData),
    .stb       (stb),
    .statQ     (descStat),
    .cntLoQ    (descCntLo),
    .addrQ     (descAddr),
    .ramWe     (ramWe),
    .ramAddr   (ramAddr),
    .ramData   (ramData),
    .stallQ    (epStall)
  );

  AST_NAK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (hsValid && (hsCode == HS_NAK) && !$past(cpuWe)) |-> $stable(descStat)); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stallIrq && !$past(cpuWe)) |-> $stable(descStat));                       // R8
endmodule

// File: tb/ep_bd_engine_bench.sv
module ep_bd_engine_bench;
  localparam int ADDR_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuWe = 1'b0;
  logic [1:0] cpuSel = '0;
  logic [ADDR_W-1:0] cpuWData = '0;
  logic [7:0] descStat, descCntLo;
  logic [ADDR_W-1:0] descAddr;
  logic tokValid = 1'b0;
  logic [1:0] tokType = '0;
  logic pidValid = 1'b0, pidTgl = 1'b0, byteValid = 1'b0, eopValid = 1'b0, rxErr = 1'b0;
  logic [7:0] byteData = '0;
  logic hsValid, ramWe, trnDone, epStall, stallIrq;
  logic [1:0] hsCode;
  logic [ADDR_W-1:0] ramAddr;
  logic [7:0] ramData;

  int checks = 0, failures = 0;
  int weCnt = 0;
  logic [ADDR_W-1:0] logA [64];
  logic [7:0] logD [64];
  logic cHs, cDone, cIrq, earlyHs;
  logic [1:0] cCode;
  bit finished = 0;

  always #4 clk = ~clk;

  ep_bd_engine #(.ADDR_W(ADDR_W)) u_ep_bd_engine (.*);

  always @(negedge clk) if (ramWe) begin
    logA[weCnt % 64] = ramAddr;
    logD[weCnt % 64] = ramData;
    weCnt++;
  end

  task automatic tick; @(posedge clk); #2; endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [1:0] sel, input int data);
    cpuWe = 1; cpuSel = sel; cpuWData = ADDR_W'(data);
    tick();
    cpuWe = 0;
  endtask

  task automatic arm(input int addr, input int len, input bit sync, input bit dts, input bit stall);
    cpuWrite(2'd2, addr);
    cpuWrite(2'd1, len & 8'hFF);
    cpuWrite(2'd0, 128 | (int'(dts) << 6) | (int'(sync) << 3) | (int'(stall) << 2) | ((len >> 8) & 3));
  endtask

  task automatic capture;
    cHs = hsValid; cCode = hsCode; cDone = trnDone; cIrq = stallIrq;
  endtask

  task automatic sendPkt(input logic [1:0] tok, input bit tgl, input int n, input bit err);
    tokValid = 1; tokType = tok; tick(); tokValid = 0;
    pidValid = 1; pidTgl = tgl; tick(); pidValid = 0;
    earlyHs = hsValid;
    for (int i = 0; i < n; i++) begin
      byteValid = 1; byteData = 8'(8'hA0 + i); tick();
      if (hsValid) earlyHs = 1;
    end
    byteValid = 0;
    eopValid = 1; rxErr = err; tick(); eopValid = 0; rxErr = 0;
    capture();
  endtask

  task automatic sendIn;
    tokValid = 1; tokType = 2'd2; tick(); tokValid = 0;
    capture();
  endtask

  task automatic t_reset;
    chk("R1 status", descStat, 0);
    chk("R1 count", descCntLo, 0);
    chk("R1 addr", descAddr, 0);
    chk("R1 outputs", {hsValid, trnDone, stallIrq, epStall, ramWe}, 0);
  endtask

  task automatic t_layout;
    cpuWrite(2'd0, 8'h0B);
    chk("R2 status write", descStat, 8'h0B);
    cpuWrite(2'd1, 8'h5A);
    chk("R2 count write", descCntLo, 8'h5A);
    cpuWrite(2'd2, 10'h123);
    chk("R2 addr write", descAddr, 10'h123);
  endtask

  task automatic t_unowned;
    int b = weCnt;
    cpuWrite(2'd0, 0);
    cpuWrite(2'd2, 10'h010);
    cpuWrite(2'd1, 8);
    sendPkt(2'd1, 0, 2, 0);
    chk("R12 not armed NAK", {cHs, cCode}, {1'b1, 2'd2});
    chk("R3 no write", weCnt - b, 0);
    chk("R3 no done", cDone, 0);
  endtask

  task automatic t_syncMatch;
    int b = weCnt;
    arm(10'h040, 8, 1, 0, 0);
    sendPkt(2'd1, 0, 4, 0);
    chk("R13 no early handshake", earlyHs, 0);
    chk("R4 ACK", {cHs, cCode}, {1'b1, 2'd1});
    chk("R4 done", cDone, 1);
    chk("R4 writes", weCnt - b, 4);
    chk("R4 first addr", logA[b % 64], 10'h040);
    chk("R4 last data", logD[(b + 3) % 64], 8'hA3);
    chk("R4 status", descStat, 8'h04);
    chk("R4 count", descCntLo, 4);
  endtask

  task automatic t_syncMismatch;
    int b = weCnt;
    arm(10'h080, 8, 1, 1, 0);
    sendPkt(2'd1, 0, 3, 0);
    chk("R5 ACK", {cHs, cCode}, {1'b1, 2'd1});
    chk("R5 no done", cDone, 0);
    chk("R5 no write", weCnt - b, 0);
    chk("R5 status kept", descStat, 8'hC8);
    chk("R5 count kept", descCntLo, 8);
  endtask

  task automatic t_noSync;
    int b = weCnt;
    arm(10'h100, 8, 0, 0, 0);
    sendPkt(2'd1, 1, 2, 0);
    chk("R6 DATA1 ACK", {cHs, cCode, cDone}, {1'b1, 2'd1, 1'b1});
    chk("R6 DATA1 writes", weCnt - b, 2);
    chk("R6 DATA1 status", descStat, 8'h44);
    b = weCnt;
    arm(10'h100, 8, 0, 1, 0);
    sendPkt(2'd1, 0, 1, 0);
    chk("R6 DATA0 ACK", {cHs, cCode, cDone}, {1'b1, 2'd1, 1'b1});
    chk("R6 DATA0 writes", weCnt - b, 1);
    chk("R6 DATA0 status", descStat, 8'h04);
  endtask

  task automatic t_error;
    arm(10'h020, 8, 1, 0, 0);
    sendPkt(2'd1, 0, 2, 1);
    chk("R7 NAK", {cHs, cCode}, {1'b1, 2'd2});
    chk("R7 no done", cDone, 0);
    chk("R7 status kept", descStat, 8'h88);
    chk("R7 count kept", descCntLo, 8);
  endtask

  task automatic t_stall;
    int b = weCnt;
    arm(10'h030, 8, 0, 0, 1);
    sendPkt(2'd1, 0, 2, 0);
    chk("R8 OUT STALL", {cHs, cCode}, {1'b1, 2'd3});
    chk("R8 irq", cIrq, 1);
    chk("R8 flag", epStall, 1);
    chk("R8 no write", weCnt - b, 0);
    chk("R8 status kept", descStat, 8'h84);
    sendIn();
    chk("R8 IN STALL", {cHs, cCode, cDone}, {1'b1, 2'd3, 1'b0});
    cpuWrite(2'd0, 8'h84);
    chk("R8 flag cleared", epStall, 0);
  endtask

  task automatic t_setup;
    int b = weCnt;
    arm(10'h030, 8, 0, 0, 1);
    sendPkt(2'd3, 0, 3, 0);
    chk("R9 ACK", {cHs, cCode, cDone}, {1'b1, 2'd1, 1'b1});
    chk("R9 writes", weCnt - b, 3);
    chk("R9 status", descStat, 8'h34);
    sendPkt(2'd1, 0, 1, 0);
    chk("R9 stall gone", {cCode, cIrq}, {2'd2, 1'b0});
  endtask

  task automatic t_in;
    arm(10'h050, 5, 1, 1, 0);
    sendIn();
    chk("R10 data code", {cHs, cCode, cDone}, {1'b1, 2'd0, 1'b1});
    chk("R10 status", descStat, 8'h64);
    chk("R10 count kept", descCntLo, 5);
    sendIn();
    chk("R3 IN unowned NAK", {cHs, cCode, cDone}, {1'b1, 2'd2, 1'b0});
  endtask

  task automatic t_trunc;
    int b = weCnt;
    arm(10'h200, 3, 0, 0, 0);
    sendPkt(2'd1, 0, 5, 0);
    chk("R11 writes truncated", weCnt - b, 3);
    chk("R11 last addr", logA[(b + 2) % 64], 10'h202);
    chk("R11 full count", descCntLo, 5);
    chk("R11 ACK", {cHs, cCode}, {1'b1, 2'd1});
    b = weCnt;
    arm(10'h000, 10'h104, 0, 0, 0);
    sendPkt(2'd1, 0, 6, 0);
    chk("R11 high count bits", weCnt - b, 6);
    chk("R2 count high", descStat[1:0], 0);
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rstN = 1;
    tick();
    t_layout();
    t_unowned();
    t_syncMatch();
    t_syncMismatch();
    t_noSync();
    t_error();
    t_stall();
    t_setup();
    t_in();
    t_trunc();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule